// File: doc/BRIEF.md
# Two-level page table walker

This block resolves a virtual address into a physical address when a translation cache has missed. It walks a page table of two levels held in ordinary memory. A start strobe hands it a table base, a 14-bit virtual address and an access type, which is read or write and user or supervisor. The walker then reads a directory word. If that word is valid, it reads the leaf entry the word points to. It then checks the leaf entry against the requested access. It returns either a physical address with the page permissions, or one of three fault kinds.

Memory is reached through a single request/acknowledge port that carries one word per transfer. Only one request is outstanding at a time, and each request stays raised until it is acknowledged. A walk that succeeds marks the leaf entry as accessed, and as dirty when the access is a write. These updates go back to memory in one write before completion is reported.

Top module: `pt_walker`

## Requirements
- R1: The virtual address is split into bits [13:10] as directory index, bits [9:6] as leaf index and bits [5:0] as page offset. The first read of a walk goes to byte address `ptbr + 4*dir_index`.
- R2: A directory word uses bit 0 as valid and bits [15:6] as the leaf table base, so the base is the word with bits [5:0] cleared. The second read goes to `base + 4*leaf_index`.
- R3: Fault codes are 0 none, 1 invalid, 2 protection and 3 not present. A directory word with bit 0 clear ends the walk with code 1 after exactly one read, and the word's other bits are ignored.
- R4: A leaf entry uses bit 0 valid, bit 1 present, bit 2 writable, bit 3 user allowed, bit 4 accessed, bit 5 dirty and bits [17:8] frame number. A leaf entry with bit 0 clear gives code 1.
- R5: A valid leaf gives code 2 when a write (`acc_write`=1) hits a page with bit 2 clear, or when a user access (`acc_user`=1) hits a page with bit 3 clear. This check takes priority over the present bit.
- R6: A valid leaf that permits the access but has bit 1 clear gives code 3.
- R7: On success the code is 0 and `res_paddr` is {frame number, offset}. `res_writable` and `res_user` copy bits 2 and 3. On any fault, all three outputs are zero.
- R8: On success the walker makes one write to the leaf entry's address. The written word is the original with bit 4 set, and with bit 5 also set for a write access; every other bit is unchanged. The write is skipped when the word would not change, and no walk that faults ever writes.
- R9: A memory request keeps its address and direction stable until `mem_ack`, and only one request is ever outstanding.
- R10: `busy` is high from the cycle after an accepted start through the cycle in which `done` is high. `done` lasts one cycle. A start, virtual address or access type presented while busy has no effect on the walk in progress, and no new walk begins.
- R11: After reset `busy`, `done` and `mem_req` are low, the fault code is 0 and `res_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a walk; taken only when idle |
| ptbr | input | 16 | Byte address of the directory |
| va | input | 14 | Virtual address to translate |
| acc_write | input | 1 | 1 for a write access |
| acc_user | input | 1 | 1 for a user-mode access |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 2 | Fault code of the last walk |
| res_paddr | output | 16 | Translated physical address |
| res_writable | output | 1 | Page writable permission |
| res_user | output | 1 | Page user permission |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
Two things can land in the same cycle. One is a new start strobe, which may arrive while an acknowledge finishes a read or while `done` is high. The other is the permission check, which runs together with the present check and the accessed/dirty update on one leaf word. The bench holds `start` high and scrambles the virtual address and access type from the second cycle of every walk until `done` is seen. It then checks that the result matches the address first presented, and that the number and addresses of the memory transfers match the expected walk, with no extra walk afterwards. Every one of the 256 page numbers is walked under all four access types, using leaf words whose flag combinations vary. This exposes every ordering of the invalid, protection and not-present conditions, along with both outcomes of the skipped write-back.

// File: rtl/ptw_pkg.sv
// Shared encodings for the page table walker: fault codes, controller
// states and bit positions inside directory and leaf words.
package ptw_pkg;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_PROT    = 2'd2,
        FLT_ABSENT  = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_RD_LEAF,
        ST_WB,
        ST_DONE
    } state_e;

    // Flag positions shared by directory and leaf words.
    localparam int E_VALID = 0;
    localparam int E_PRES  = 1;
    localparam int E_WR    = 2;
    localparam int E_USER  = 3;
    localparam int E_ACC   = 4;
    localparam int E_DIRTY = 5;
    // Lowest bit of the frame number in a leaf word.
    localparam int PFN_LSB = 8;

endpackage

// File: rtl/ptw_addr_gen.sv
// Forms the memory address of the current walk step.
// Assumes each index selects a 4-byte word; the directory step
// adds to the base register and the leaf step adds to the latched
// leaf table base, whose low bits are implied zero.
module ptw_addr_gen #(
    parameter int PA_W  = 16,
    parameter int DIR_W = 4,
    parameter int TBL_W = 4
) (
    input  logic                      sel_leaf,
    input  logic [PA_W-1:0]           ptbr,
    input  logic [DIR_W-1:0]          dir_idx,
    input  logic [TBL_W-1:0]          tbl_idx,
    input  logic [PA_W-TBL_W-3:0]     leaf_base,
    output logic [PA_W-1:0]           addr
);
    localparam int ALIGN = TBL_W + 2;

    logic [PA_W-1:0] dir_addr;
    logic [PA_W-1:0] leaf_addr;

    // Purpose: compute both candidate addresses and pick the active step.
    always_comb begin
        dir_addr  = ptbr + PA_W'({dir_idx, 2'b00});
        leaf_addr = {leaf_base, {ALIGN{1'b0}}} + PA_W'({tbl_idx, 2'b00});
        addr      = sel_leaf ? leaf_addr : dir_addr;
    end
endmodule

// File: rtl/ptw_entry_check.sv
// Judges a leaf word against the requested access and prepares the
// word with accessed/dirty marks. Purely combinational; works on the
// word as it arrives from memory.
module ptw_entry_check
    import ptw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] entry,
    input  logic              is_write,
    input  logic              is_user,
    output fault_e            fault,
    output logic [DATA_W-1:0] marked,
    output logic              needs_wb
);
    logic perm_ok;

    // Purpose: prioritised fault decision and accessed/dirty marking.
    always_comb begin
        perm_ok = !(is_write && !entry[E_WR]) && !(is_user && !entry[E_USER]);
        if (!entry[E_VALID])     fault = FLT_INVALID;
        else if (!perm_ok)       fault = FLT_PROT;
        else if (!entry[E_PRES]) fault = FLT_ABSENT;
        else                     fault = FLT_NONE;
        marked           = entry;
        marked[E_ACC]    = 1'b1;
        if (is_write) marked[E_DIRTY] = 1'b1;
        needs_wb = (marked != entry);
    end
endmodule

// File: rtl/ptw_ctrl.sv
// Sequencer of the walk: idle, directory read, leaf read, optional
// write-back, done. Each memory step waits for its acknowledge.
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic mem_ack,
    input  logic dir_ok,
    input  logic leaf_ok,
    input  logic wb_needed,
    output logic busy,
    output logic done,
    output logic mem_req,
    output logic mem_we,
    output logic sel_leaf,
    output logic accept,
    output logic dir_cap,
    output logic leaf_cap
);
    state_e st_q, st_d;

    // Purpose: next-state decision.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:    if (start) st_d = ST_RD_DIR;
            ST_RD_DIR:  if (mem_ack) st_d = dir_ok ? ST_RD_LEAF : ST_DONE;
            ST_RD_LEAF: if (mem_ack) st_d = (leaf_ok && wb_needed) ? ST_WB : ST_DONE;
            ST_WB:      if (mem_ack) st_d = ST_DONE;
            ST_DONE:    st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // Purpose: state register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Purpose: decode state into port controls and capture strobes.
    always_comb begin
        busy     = (st_q != ST_IDLE);
        done     = (st_q == ST_DONE);
        mem_req  = (st_q == ST_RD_DIR) || (st_q == ST_RD_LEAF) || (st_q == ST_WB);
        mem_we   = (st_q == ST_WB);
        sel_leaf = (st_q == ST_RD_LEAF) || (st_q == ST_WB);
        accept   = (st_q == ST_IDLE) && start;
        dir_cap  = (st_q == ST_RD_DIR) && mem_ack;
        leaf_cap = (st_q == ST_RD_LEAF) && mem_ack;
    end
endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker. Latches its request at start, reads a
// directory word and a leaf word, reports a translation or a fault,
// and writes back accessed/dirty marks on success.
// Assumes the directory and each leaf table are aligned to their size.
module pt_walker
    import ptw_pkg::*;
#(
    parameter int PA_W   = 16,
    parameter int DATA_W = 32,
    parameter int DIR_W  = 4,
    parameter int TBL_W  = 4,
    parameter int OFF_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PA_W-1:0]   ptbr,
    input  logic [DIR_W+TBL_W+OFF_W-1:0] va,
    input  logic              acc_write,
    input  logic              acc_user,
    output logic              busy,
    output logic              done,
    output logic [1:0]        fault,
    output logic [PA_W-1:0]   res_paddr,
    output logic              res_writable,
    output logic              res_user,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int VA_W  = DIR_W + TBL_W + OFF_W;
    localparam int PFN_W = PA_W - OFF_W;
    localparam int ALIGN = TBL_W + 2;
    localparam int BASE_W = PA_W - ALIGN;

    logic [VA_W-1:0]   va_q;
    logic [PA_W-1:0]   ptbr_q;
    logic              wr_q, usr_q;
    logic [BASE_W-1:0] base_q;
    logic [DATA_W-1:0] entry_q;
    fault_e            fault_q;

    logic   sel_leaf, accept, dir_cap, leaf_cap;
    fault_e chk_fault;
    logic [DATA_W-1:0] chk_marked;
    logic   chk_wb;

    ptw_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mem_ack   (mem_ack),
        .dir_ok    (mem_rdata[E_VALID]),
        .leaf_ok   (chk_fault == FLT_NONE),
        .wb_needed (chk_wb),
        .busy      (busy),
        .done      (done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .sel_leaf  (sel_leaf),
        .accept    (accept),
        .dir_cap   (dir_cap),
        .leaf_cap  (leaf_cap)
    );

    ptw_addr_gen #(.PA_W(PA_W), .DIR_W(DIR_W), .TBL_W(TBL_W)) u_addr (
        .sel_leaf  (sel_leaf),
        .ptbr      (ptbr_q),
        .dir_idx   (va_q[VA_W-1 -: DIR_W]),
        .tbl_idx   (va_q[OFF_W +: TBL_W]),
        .leaf_base (base_q),
        .addr      (mem_addr)
    );

    ptw_entry_check #(.DATA_W(DATA_W)) u_check (
        .entry    (mem_rdata),
        .is_write (wr_q),
        .is_user  (usr_q),
        .fault    (chk_fault),
        .marked   (chk_marked),
        .needs_wb (chk_wb)
    );

    // Purpose: latch request, directory base, leaf word and fault code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q    <= '0;
            ptbr_q  <= '0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            base_q  <= '0;
            entry_q <= '0;
            fault_q <= FLT_NONE;
        end else if (accept) begin
            va_q    <= va;
            ptbr_q  <= ptbr;
            wr_q    <= acc_write;
            usr_q   <= acc_user;
            fault_q <= FLT_NONE;
        end else if (dir_cap) begin
            base_q <= mem_rdata[PA_W-1:ALIGN];
            if (!mem_rdata[E_VALID]) fault_q <= FLT_INVALID;
        end else if (leaf_cap) begin
            entry_q <= chk_marked;
            fault_q <= chk_fault;
        end
    end

    // Purpose: present results, masked to zero on a fault.
    always_comb begin
        fault     = fault_q;
        mem_wdata = entry_q;
        if (fault_q == FLT_NONE) begin
            res_paddr    = {entry_q[PFN_LSB +: PFN_W], va_q[OFF_W-1:0]};
            res_writable = entry_q[E_WR];
            res_user     = entry_q[E_USER];
        end else begin
            res_paddr    = '0;
            res_writable = 1'b0;
            res_user     = 1'b0;
        end
    end
endmodule

// File: rtl/pt_walker_checker.sv
// Property checker for the page table walker, attached by bind.
module pt_walker_checker #(
    parameter int PA_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic [1:0]      fault,
    input logic [PA_W-1:0] res_paddr,
    input logic            mem_req,
    input logic            mem_we,
    input logic [PA_W-1:0] mem_addr,
    input logic            mem_ack,
    input logic            wb_valid,
    input logic            wb_present,
    input logic            wb_acc
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy); // R10

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy && !done); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R10

    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy && !mem_req); // R10

    AST_WB_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> wb_valid && wb_present && wb_acc); // R8

    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done && (fault != 2'd0) |-> res_paddr == '0); // R7
endmodule

bind pt_walker pt_walker_checker #(.PA_W(PA_W)) u_pt_walker_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .fault      (fault),
    .res_paddr  (res_paddr),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .wb_valid   (mem_wdata[ptw_pkg::E_VALID]),
    .wb_present (mem_wdata[ptw_pkg::E_PRES]),
    .wb_acc     (mem_wdata[ptw_pkg::E_ACC])
);

// File: tb/test_pt_walker.sv
`timescale 1ns/100ps
// Sweeps every page number under every access type against a small
// memory model with varying acknowledge latency.
module test_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] ptbr = '0;
    logic [13:0] va = '0;
    logic        acc_write = 1'b0, acc_user = 1'b0;
    logic        busy, done;
    logic [1:0]  fault;
    logic [15:0] res_paddr;
    logic        res_writable, res_user;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [0:255];
    int lat = 0, wait_cnt = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [15:0] rd_addr [0:3];
    logic [15:0] wr_addr;
    logic [31:0] wr_data;

    localparam logic [15:0] DIR_BASE = 16'h0380;

    always #2.5 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .ptbr(ptbr), .va(va),
        .acc_write(acc_write), .acc_user(acc_user), .busy(busy), .done(done),
        .fault(fault), .res_paddr(res_paddr), .res_writable(res_writable),
        .res_user(res_user), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    // Memory model: acknowledges after lat idle cycles, logs transfers.
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_ack = 1'b1;
                wait_cnt = 0;
                if (mem_we) begin
                    mem[mem_addr[9:2]] = mem_wdata;
                    wr_addr = mem_addr;
                    wr_data = mem_wdata;
                    wr_cnt++;
                end else begin
                    mem_rdata = mem[mem_addr[9:2]];
                    if (rd_cnt < 4) rd_addr[rd_cnt] = mem_addr;
                    rd_cnt++;
                end
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    function automatic logic dir_valid(input int d);
        return (d % 2) == 0;
    endfunction

    function automatic logic [31:0] dir_word(input int d);
        if (dir_valid(d)) return 32'h0000_0001 | 32'(64 * (d / 2 + 1));
        return 32'hFFFF_FFC0;
    endfunction

    function automatic logic [31:0] leaf_word(input int d, input int t);
        logic [5:0]  fl;
        logic [9:0]  pfn;
        logic [13:0] hi;
        fl  = 6'((d * 5 + t * 3 + 1) & 63);
        pfn = 10'((d * 16 + t) ^ 341);
        hi  = 14'(d * t + 3);
        return {hi, pfn, 2'b11, fl};
    endfunction

    task automatic walk(input int d, input int t, input bit w, input bit u, input int l);
        logic [31:0] lw, exp_wb;
        logic [13:0] va0;
        logic [1:0]  ef;
        logic [15:0] laddr;
        int cyc;
        bit perm_ok;
        lw    = leaf_word(d, t);
        laddr = 16'(64 * (d / 2 + 1) + 4 * t);
        if (dir_valid(d)) mem[laddr[9:2]] = lw;
        va0 = {4'(d), 4'(t), 6'((d * 7 + t * 13) & 63)};
        // expected fault: R3 R4 R5 R6
        perm_ok = !(w && !lw[2]) && !(u && !lw[3]);
        if (!dir_valid(d))  ef = 2'd1;
        else if (!lw[0])    ef = 2'd1;
        else if (!perm_ok)  ef = 2'd2;
        else if (!lw[1])    ef = 2'd3;
        else                ef = 2'd0;
        exp_wb = lw | 32'h10 | (w ? 32'h20 : 32'h0);
        @(negedge clk);
        lat = l; rd_cnt = 0; wr_cnt = 0; wait_cnt = 0;
        ptbr = DIR_BASE; va = va0; acc_write = w; acc_user = u; start = 1'b1;
        @(negedge clk);
        // R10: scramble inputs and keep start high while busy
        va = ~va0; acc_write = ~w; acc_user = ~u; ptbr = 16'h0000;
        cyc = 0;
        while (!done && cyc < 100) begin @(negedge clk); cyc++; end
        start = 1'b0;
        check(done, "R10", "done seen", done, 1);
        check(busy, "R10", "busy with done", busy, 1);
        check(fault == ef, "R5", "fault code", fault, ef);
        if (ef == 2'd0) begin
            check(res_paddr == {lw[17:8], va0[5:0]}, "R7", "paddr", res_paddr, {lw[17:8], va0[5:0]});
            check(res_writable == lw[2] && res_user == lw[3], "R7", "perms",
                  {res_writable, res_user}, {lw[2], lw[3]});
        end else begin
            check(res_paddr == 0 && !res_writable && !res_user, "R7", "zero on fault",
                  {res_paddr, res_writable, res_user}, 0);
        end
        repeat (3) @(negedge clk);
        check(!busy && !done, "R10", "idle after walk, no second walk", {busy, done}, 0);
        // R1 R2 R3: transfer counts and addresses
        check(rd_cnt == (dir_valid(d) ? 2 : 1), "R3", "read count", rd_cnt, dir_valid(d) ? 2 : 1);
        check(rd_addr[0] == DIR_BASE + 16'(4 * d), "R1", "directory address",
              rd_addr[0], DIR_BASE + 16'(4 * d));
        if (dir_valid(d))
            check(rd_addr[1] == laddr, "R2", "leaf address", rd_addr[1], laddr);
        // R8: write-back
        if (ef == 2'd0 && exp_wb != lw) begin
            check(wr_cnt == 1, "R8", "write count", wr_cnt, 1);
            check(wr_addr == laddr && wr_data == exp_wb, "R8", "write word", wr_data, exp_wb);
            check(mem[laddr[9:2]] == exp_wb, "R8", "memory after", mem[laddr[9:2]], exp_wb);
        end else begin
            check(wr_cnt == 0, "R8", "no write", wr_cnt, 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
        for (int d = 0; d < 16; d++) mem[(DIR_BASE >> 2) + d] = dir_word(d);
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!busy && !done && !mem_req, "R11", "controls after reset",
              {busy, done, mem_req}, 0);
        check(fault == 2'd0 && res_paddr == 0, "R11", "results after reset",
              {fault, res_paddr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_req, "R11", "idle without start", {busy, mem_req}, 0);
        // Full sweep: all page numbers, all access types, R9 latency varied.
        for (int d = 0; d < 16; d++)
            for (int t = 0; t < 16; t++)
                for (int a = 0; a < 4; a++)
                    walk(d, t, a[0], a[1], (d + t + a) % 3);
        finish_run();
    end
endmodule